// File: doc/BRIEF.md
# Cooperative Round-Robin Context Scheduler

This block decides which of eight hardware thread contexts in a multi-threaded packet engine owns the issue slot. The owning context keeps the slot for as long as it wants. It gives the slot up only by raising a yield strobe. On a yield, the scheduler hands the slot to the next ready context in cyclic order. The yielding context is the last one considered. The hand-over costs no idle cycles.

Each context has a ready flag. A per-context wake input sets the flag. A yield clears the yielding context's flag, unless a wake for that context arrives in the same cycle. If nothing is ready after a yield, the scheduler reports that no context is active. It waits until some flag is set, then grants the first ready context that follows the last one to yield.

Top module: `ctx_sched`

## Requirements
- R1: After reset, all eight ready flags are set, `activeCtx` is 0, `activeValid` is 1 and `switchPulse` is 0. The last-yielder pointer is 7.
- R2: While `activeValid` is 1 and `yield` is 0, `activeCtx` and `activeValid` hold their values on the next clock edge, whatever the `wake` inputs do.
- R3: On an accepted yield, the new `activeCtx` is the first context with its ready flag set, searching upward from the yielder plus one. The order is 0,1,...,7, wrapping from 7 to 0.
- R4: When a yield finds a ready context, the new index and `activeValid`=1 appear on the clock edge that samples the yield, with no gap cycle.
- R5: A `wake[i]` high at a clock edge sets the ready flag of context i. An accepted yield clears the yielder's flag at that edge, unless `wake` for that context is high in the same cycle.
- R6: The yielding context is searched last. It is granted again only if it is the only ready context after the yield.
- R7: If an accepted yield finds no ready context, `activeValid` is 0 from that clock edge on.
- R8: While `activeValid` is 0 and some ready flag is set, the next edge grants the first ready context after the last yielder, in cyclic order, and sets `activeValid`. A wake therefore leads to a grant two edges later.
- R9: `yield` is ignored while `activeValid` is 0. It neither changes the state nor moves the last-yielder pointer.
- R10: `switchPulse` is 1 for the one cycle after an edge where `activeCtx` changes, or where a context is granted out of idle. It is 0 when a yielder is granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake | input | 8 | Per-context ready-set strobes |
| yield | input | 1 | Voluntary release by the active context |
| activeCtx | output | 3 | Index of the context owning the issue slot |
| activeValid | output | 1 | High when some context owns the slot |
| switchPulse | output | 1 | One-cycle marker of a new grant |

## Verification
The stimulus starts with a full sweep of yields from the reset state, where every context is ready. This sweep separates plain incremental selection from a wrong starting point, and its end shows the drop to idle. Sparse ready sets are used next. They show whether the search skips non-ready contexts and wraps from 7 to 0, and whether the yielder is searched last. Yields that carry their own wake tell a self-regrant without a pulse apart from a real switch. Wakes during a held grant test that the block is non-preemptive. Yields while idle, followed by several wakes, show that the idle grant starts from the last yielder.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;
  typedef struct packed {
    logic takeYield;   // accepted yield this cycle
    logic loadActive;  // load the search result as the new owner
  } schedStrobe_t;
endpackage

// File: rtl/ctx_sched_dp.sv
module ctx_sched_dp
  import ctx_sched_pkg::*;
#(
  parameter int NUM_CTX = 8,
  localparam int IDX_W = $clog2(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTX-1:0] wake,
  input  schedStrobe_t       str,
  input  logic               activeValid,
  output logic [IDX_W-1:0]   activeCtx,
  output logic [IDX_W-1:0]   pickIdx,
  output logic               pickAny,
  output logic               pickDiffers
);
  logic [NUM_CTX-1:0] readyQ, readyNext, searchVec, yieldMask;
  logic [IDX_W-1:0]   lastYield, baseIdx, startIdx;

  always_comb begin
    yieldMask = '0;
    if (str.takeYield) yieldMask[activeCtx] = 1'b1;
  end

  assign readyNext = (readyQ & ~yieldMask) | wake;
  assign searchVec = activeValid ? readyNext : readyQ;
  assign baseIdx   = activeValid ? activeCtx : lastYield;
  assign startIdx  = (int'(baseIdx) == NUM_CTX - 1) ? '0 : baseIdx + 1'b1;

  // cyclic first-set search beginning at startIdx; base index comes last
  always_comb begin
    pickAny = 1'b0;
    pickIdx = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      int pos;
      pos = (int'(startIdx) + i) % NUM_CTX;
      if (!pickAny && searchVec[pos]) begin
        pickAny = 1'b1;
        pickIdx = IDX_W'(pos);
      end
    end
  end

  assign pickDiffers = (pickIdx != activeCtx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readyQ    <= '1;
      activeCtx <= '0;
      lastYield <= IDX_W'(NUM_CTX - 1);
    end else begin
      readyQ <= readyNext;
      if (str.loadActive) activeCtx <= pickIdx;
      if (str.takeYield)  lastYield <= activeCtx;
    end
  end

  // R2: owner index holds without an accepted yield
  p_hold_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    activeValid && !str.takeYield |=> $stable(activeCtx));

  // R5: yielder flag cleared when no wake for it arrives
  p_ready_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    str.takeYield && !wake[activeCtx] |=> !readyQ[$past(activeCtx)]);

  // R8: a load always lands on a ready context
  p_grant_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    str.loadActive |-> searchVec[pickIdx]);
endmodule

// File: rtl/ctx_sched_ctrl.sv
module ctx_sched_ctrl
  import ctx_sched_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         yieldIn,
  input  logic         pickAny,
  input  logic         pickDiffers,
  output schedStrobe_t str,
  output logic         activeValid,
  output logic         switchPulse
);
  logic validNext, pulseNext;

  always_comb begin
    str.takeYield  = yieldIn && activeValid;
    str.loadActive = pickAny && (str.takeYield || !activeValid);
    if (!activeValid)       validNext = pickAny;
    else if (str.takeYield) validNext = pickAny;
    else                    validNext = 1'b1;
    pulseNext = str.loadActive && (!activeValid || pickDiffers);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeValid <= 1'b1;
      switchPulse <= 1'b0;
    end else begin
      activeValid <= validNext;
      switchPulse <= pulseNext;
    end
  end

  // R2: no yield keeps the slot owned
  p_keep_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    activeValid && !yieldIn |=> activeValid);

  // R4: a successful hand-over leaves no gap
  p_no_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    activeValid && yieldIn && pickAny |=> activeValid);

  // R9: idle with nothing ready stays idle, yield or not
  p_idle_stay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !activeValid && !pickAny |=> !activeValid && !switchPulse);

  // R10: pulse only marks an owned slot
  p_pulse_owned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    switchPulse |-> activeValid);
endmodule

// File: rtl/ctx_sched.sv
module ctx_sched
  import ctx_sched_pkg::*;
#(
  parameter int NUM_CTX = 8,
  localparam int IDX_W = $clog2(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTX-1:0] wake,
  input  logic               yield,
  output logic [IDX_W-1:0]   activeCtx,
  output logic               activeValid,
  output logic               switchPulse
);
  schedStrobe_t str;
  logic [IDX_W-1:0] pickIdx;
  logic pickAny, pickDiffers;

  ctx_sched_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .yieldIn(yield), .pickAny(pickAny),
    .pickDiffers(pickDiffers), .str(str), .activeValid(activeValid),
    .switchPulse(switchPulse)
  );

  ctx_sched_dp #(.NUM_CTX(NUM_CTX)) u_dp (
    .clk(clk), .rst_n(rst_n), .wake(wake), .str(str),
    .activeValid(activeValid), .activeCtx(activeCtx), .pickIdx(pickIdx),
    .pickAny(pickAny), .pickDiffers(pickDiffers)
  );
endmodule

// File: tb/ctx_sched_tb.sv
module ctx_sched_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wake = '0;
  logic       yield = 1'b0;
  logic [2:0] activeCtx;
  logic       activeValid, switchPulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] ctx;
    logic       valid;
    logic       pulse;
    string      tag;
  } expItem_t;
  expItem_t sb[$];

  // bench-side model state
  logic [7:0] mReady;
  logic [2:0] mAct, mLast;
  logic       mValid;

  always #2 clk = ~clk;

  ctx_sched u_dut (
    .clk(clk), .rst_n(rst_n), .wake(wake), .yield(yield),
    .activeCtx(activeCtx), .activeValid(activeValid), .switchPulse(switchPulse)
  );

  function automatic bit findNext(input logic [7:0] vec, input logic [2:0] after,
                                  output logic [2:0] who);
    for (int k = 1; k <= 8; k++) begin
      logic [2:0] c;
      c = after + 3'(k);
      if (vec[c]) begin
        who = c;
        return 1'b1;
      end
    end
    who = '0;
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [2:0] ec, input logic ev, input logic ep);
    checks++;
    if (activeValid !== ev || switchPulse !== ep || (ev && activeCtx !== ec)) begin
      errors++;
      $display("FAIL %s: got ctx=%0d valid=%0b pulse=%0b, expected ctx=%0d valid=%0b pulse=%0b",
               tag, activeCtx, activeValid, switchPulse, ec, ev, ep);
    end
  endtask

  // driver: one cycle of stimulus, pushes the expected post-edge outputs
  task automatic step(input logic [7:0] w, input logic y, input string tag);
    expItem_t it;
    logic [7:0] nr;
    logic [2:0] who;
    bit found;
    logic pulse;
    @(negedge clk);
    wake  = w;
    yield = y;
    pulse = 1'b0;
    nr = mReady;
    if (mValid && y) begin
      nr[mAct] = 1'b0;
      nr = nr | w;
      found = findNext(nr, mAct, who);
      mLast = mAct;
      if (found) begin
        pulse = (who != mAct);
        mAct = who;
      end else begin
        mValid = 1'b0;
      end
    end else if (!mValid) begin
      found = findNext(mReady, mLast, who);
      if (found) begin
        mAct = who;
        mValid = 1'b1;
        pulse = 1'b1;
      end
      nr = nr | w;
    end else begin
      nr = nr | w;
    end
    mReady = nr;
    it.ctx = mAct; it.valid = mValid; it.pulse = pulse; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares one expected item per edge, shortly after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        expItem_t it;
        it = sb.pop_front();
        check(it.tag, it.ctx, it.valid, it.pulse);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mReady = '1; mAct = 3'd0; mLast = 3'd7; mValid = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", 3'd0, 1'b1, 1'b0);

    // R3 R4 R10: sweep of yields with everyone ready, 0->1->...->7
    for (int i = 0; i < 7; i++) step(8'h00, 1'b1, "R3 R4 R10 sweep");
    // R7: yield from 7 with nothing left ready -> idle
    step(8'h00, 1'b1, "R7 drop to idle");
    // R9: yields while idle are ignored
    step(8'h00, 1'b1, "R9 yield while idle");
    step(8'h00, 1'b1, "R9 yield while idle");
    // R8: wake 3 and 5; grant from after last yielder (7) -> 3, two edges on
    step(8'h28, 1'b0, "R8 wake while idle");
    step(8'h00, 1'b0, "R8 idle grant");
    // R2: wakes during a held grant do not preempt
    step(8'h80, 1'b0, "R2 hold with wake");
    step(8'h01, 1'b0, "R2 hold with wake");
    step(8'h00, 1'b0, "R2 hold");
    // R3: yield from 3 skips non-ready 4 -> 5
    step(8'h00, 1'b1, "R3 skip to next ready");
    // R3 wrap: from 5, 7 ready -> 7; then 7 -> 0 (wake 0 earlier)
    step(8'h00, 1'b1, "R3 next above");
    step(8'h00, 1'b1, "R3 wrap to 0");
    // R5 R6 R10: yield from 0 with own wake, nothing else -> regrant 0, no pulse
    step(8'h01, 1'b1, "R5 R6 R10 self regrant");
    // R5: same-cycle wake for another context gets picked, 0 -> 2
    step(8'h04, 1'b1, "R5 wake with yield");
    // R5: flag of 0 was cleared by the earlier yield -> yield from 2 goes idle
    step(8'h00, 1'b1, "R5 R7 cleared flag");
    // R8: wake 1 and 6, last yielder 2 -> grant 6
    step(8'h42, 1'b0, "R8 wake while idle");
    step(8'h00, 1'b0, "R8 idle grant after last yielder");
    // R6: 1 ready, yield from 6 -> 1 (not 6)
    step(8'h00, 1'b1, "R6 yielder last");
    step(8'h00, 1'b0, "R2 hold");
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule